// File: doc/BRIEF.md
# Protected Key Register with Length-Selectable Self-Test Generator

This block keeps a fixed secret key in a bank of flip-flops while the chip runs normally. A key consumer elsewhere reads the key word. Raising the test-mode input converts the same flip-flops into a linear feedback shift register. That register generates patterns for built-in self-test. Its feedback length is picked by a two-bit selector from 4, 8, 16 or 32 stages.

On the way into test mode the key is erased before anything else happens. The register is then loaded with a fixed nonzero seed. The key therefore never reaches the scan path. The register state leaves the block only through a serial scan output, and the tester compares that stream with a golden response.

When test mode drops, the key is restored on the next clock.

Top module: `secure_key_bist`

## Requirements
- R1: While reset (`rst_n` low at a clock edge) is applied, the register loads `KEY_VALUE`. After reset, `key_out` equals `KEY_VALUE` and `scan_out` is 0.
- R2: While `test_mode` is low, `key_out` equals `KEY_VALUE` every cycle, `scan_out` stays 0, and `scan_en` has no effect.
- R3: At the first clock edge that sees `test_mode` high while in safe mode, the register is cleared to zero. During that clearing cycle `scan_out` is 0 whatever `scan_en` is.
- R4: At the following edge, the register is loaded with `SEED` masked to the active length. The length is selected by `len_sel`: 00 gives 4 bits, 01 gives 8, 10 gives 16 and 11 gives 32, always the lowest bits. All bits above the active length are 0.
- R5: With `scan_en` low in test mode, each edge shifts the active bits one place toward the MSB. Bit 0 receives the XOR of these bits of the previous state: for 4 bits, bits 3 and 2; for 8, bits 7,5,4,3; for 16, bits 15,13,12,10; for 32, bits 31,21,1,0. Bits above the length stay 0.
- R6: For every length L the sequence returns to the seed after exactly 2^L-1 steps and never reaches zero.
- R7: With `scan_en` high in test mode, `scan_out` shows register bit 0. Each edge rotates the active bits one place toward bit 0, with bit 0 moving to bit L-1. L such shifts therefore restore the state, and the generator does not advance.
- R8: A change of `len_sel` during test mode reseeds the register at the next edge with the seed masked to the new length. The reseed takes priority over a scan shift in the same cycle.
- R9: An edge that sees `test_mode` low reloads `KEY_VALUE`, taking priority over any shift or step. `scan_out` is 0 from then on, even with `scan_en` held high.
- R10: From the first edge in test mode onward, `key_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| test_mode | input | 1 | 1 selects test mode, 0 selects safe mode |
| len_sel | input | 2 | Generator length: 4, 8, 16 or 32 bits |
| scan_en | input | 1 | Serial scan shifting in test mode |
| key_out | output | KEY_W | Key word to the consumer, zero in test mode |
| scan_out | output | 1 | Serial register bit toward the tester |

## Verification
Two pairs of actions can fall in the same cycle.

- **Reseed against scan shift.** The bench changes `len_sel` in the very cycle that `scan_en` is raised. It then reads the state back and expects the bare seed of the new length, with no rotation applied.
- **Key reload against scan shift.** The bench drops `test_mode` while `scan_en` is held high. It expects the key on `key_out` and a silent `scan_out` from the next cycle.

Each length is swept against an arithmetic model. The 4-bit and 8-bit sequences are read back after every step through the full period. The 16-bit and 32-bit sequences are read back at chosen points.

// File: rtl/skb_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the protected key register.
// Assumes the register is at least 32 bits wide so the longest tap set fits.
package skb_pkg;

    // Operating phase of the register bank.
    typedef enum logic [1:0] {
        PH_SAFE  = 2'd0,
        PH_CLEAR = 2'd1,
        PH_RUN   = 2'd2
    } phase_e;

    // Per-cycle operation applied to every stage.
    typedef enum logic [2:0] {
        OP_KEY   = 3'd0,
        OP_ZERO  = 3'd1,
        OP_SEED  = 3'd2,
        OP_SHIFT = 3'd3,
        OP_STEP  = 3'd4
    } op_e;

    localparam int NUM_LEN = 4;
    localparam int MIN_W   = 32;

    // Feedback tap mask for length option k (bit e-1 for each term x^e).
    function automatic logic [31:0] tap_mask(input int k);
        case (k)
            0:       return 32'h0000_000C;
            1:       return 32'h0000_00B8;
            2:       return 32'h0000_B400;
            default: return 32'h8020_0003;
        endcase
    endfunction

    // Active length in stages for a selector value.
    function automatic int len_of(input logic [1:0] sel);
        return 4 << sel;
    endfunction

endpackage

// File: rtl/skb_tap_select.sv
`timescale 1ns/1ps
// Feedback generator: one XOR tree per length option and a 4-to-1 selector.
// Assumes W >= 32; only the low 32 bits can carry taps.
module skb_tap_select
    import skb_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] state,
    input  logic [1:0]   sel,
    output logic         fb
);

    logic [NUM_LEN-1:0] part;

    // One parity tree per selectable polynomial.
    for (genvar k = 0; k < NUM_LEN; k++) begin : g_tree
        assign part[k] = ^(state[31:0] & tap_mask(k));
    end

    // Pick the feedback of the active length.
    assign fb = part[sel];

endmodule

// File: rtl/skb_stage_array.sv
`timescale 1ns/1ps
// Per-stage next-value multiplexers for the key / generator register.
// Each stage picks key, zero, seed, scan rotation or generator shift.
// Stages at or above the active length take zero except in key load.
module skb_stage_array
    import skb_pkg::*;
#(
    parameter int W = 32
) (
    input  op_e          op,
    input  logic [1:0]   len_sel,
    input  logic         fb,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] key,
    input  logic [W-1:0] seed,
    output logic [W-1:0] nxt
);

    for (genvar i = 0; i < W; i++) begin : g_stage
        logic in_len;
        logic is_top;
        logic from_up;
        logic from_low;
        logic bit_n;

        assign in_len = (i < len_of(len_sel));
        assign is_top = (i == len_of(len_sel) - 1);

        // Neighbour toward bit 0 for the scan rotation.
        if (i == W - 1) begin : g_wrap
            assign from_up = cur[0];
        end else begin : g_next
            assign from_up = is_top ? cur[0] : cur[i+1];
        end

        // Neighbour toward the MSB for the generator shift.
        if (i == 0) begin : g_fb
            assign from_low = fb;
        end else begin : g_prev
            assign from_low = cur[i-1];
        end

        // Stage multiplexer selected by the current operation.
        always_comb begin
            case (op)
                OP_KEY:   bit_n = key[i];
                OP_ZERO:  bit_n = 1'b0;
                OP_SEED:  bit_n = in_len & seed[i];
                OP_SHIFT: bit_n = in_len & from_up;
                OP_STEP:  bit_n = in_len & from_low;
                default:  bit_n = 1'b0;
            endcase
        end

        assign nxt[i] = bit_n;
    end

endmodule

// File: rtl/skb_mode_ctrl.sv
`timescale 1ns/1ps
// Mode sequencer: safe -> clear -> run, and back to safe whenever test mode drops.
// Also tracks the length in use to detect selector changes.
// Assumes rst_n is synchronous and active low.
module skb_mode_ctrl
    import skb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       test_mode,
    input  logic [1:0] len_sel,
    input  logic       scan_en,
    output phase_e     phase,
    output op_e        op,
    output logic [1:0] len_q
);

    phase_e phase_n;

    // Decide this cycle's register operation, by priority.
    always_comb begin
        if (!test_mode) begin
            op = OP_KEY;
        end else begin
            case (phase)
                PH_SAFE:  op = OP_ZERO;
                PH_CLEAR: op = OP_SEED;
                default:  op = (len_sel != len_q) ? OP_SEED :
                               (scan_en ? OP_SHIFT : OP_STEP);
            endcase
        end
    end

    // Next phase of the sequence.
    always_comb begin
        if (!test_mode) begin
            phase_n = PH_SAFE;
        end else begin
            case (phase)
                PH_SAFE:  phase_n = PH_CLEAR;
                default:  phase_n = PH_RUN;
            endcase
        end
    end

    // Phase and length registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_SAFE;
            len_q <= 2'b00;
        end else begin
            phase <= phase_n;
            if (op == OP_SEED) begin
                len_q <= len_sel;
            end
        end
    end

    // R3, R4: entry passes through clear before run.
    p_entry_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SAFE && test_mode) |=> (phase == PH_CLEAR));

    // R9: dropping test mode always lands in safe.
    p_exit_safe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |=> (phase == PH_SAFE));

endmodule

// File: rtl/secure_key_bist.sv
`timescale 1ns/1ps
// Protected key register. Holds KEY_VALUE in safe mode. In test mode it is
// wiped, seeded and run as a length-selectable LFSR read out by scan.
// Assumes KEY_W >= 32 and SEED has a nonzero low nibble.
module secure_key_bist
    import skb_pkg::*;
#(
    parameter int               KEY_W     = 32,
    parameter logic [KEY_W-1:0] KEY_VALUE = 32'hC3A5_96E1,
    parameter logic [KEY_W-1:0] SEED      = 32'h0000_0001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             test_mode,
    input  logic [1:0]       len_sel,
    input  logic             scan_en,
    output logic [KEY_W-1:0] key_out,
    output logic             scan_out
);

    phase_e           phase;
    op_e              op;
    logic [1:0]       len_q;
    logic             fb;
    logic [KEY_W-1:0] key_q;
    logic [KEY_W-1:0] key_n;

    // Mask of the active low bits for a selector value.
    function automatic logic [KEY_W-1:0] len_mask(input logic [1:0] sel);
        logic [KEY_W-1:0] m;
        for (int i = 0; i < KEY_W; i++) begin
            m[i] = (i < len_of(sel));
        end
        return m;
    endfunction

    skb_mode_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_mode (test_mode),
        .len_sel   (len_sel),
        .scan_en   (scan_en),
        .phase     (phase),
        .op        (op),
        .len_q     (len_q)
    );

    skb_tap_select #(.W(KEY_W)) u_taps (
        .state (key_q),
        .sel   (len_sel),
        .fb    (fb)
    );

    skb_stage_array #(.W(KEY_W)) u_stages (
        .op      (op),
        .len_sel (len_sel),
        .fb      (fb),
        .cur     (key_q),
        .key     (KEY_VALUE),
        .seed    (SEED),
        .nxt     (key_n)
    );

    // Register bank shared by key storage and pattern generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= KEY_VALUE;
        end else begin
            key_q <= key_n;
        end
    end

    // Key is visible to the consumer only in safe phase.
    assign key_out  = (phase == PH_SAFE) ? key_q : '0;
    // Scan path is live only while running in test mode.
    assign scan_out = (phase == PH_RUN) && test_mode && scan_en && key_q[0];

    // R2, R9: an edge in safe mode leaves the key in the bank.
    p_key_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |=> (key_q == KEY_VALUE));

    // R3: entering test wipes the bank.
    p_clear_on_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SAFE && test_mode) |=> (key_q == '0));

    // R4: the clear is followed by the masked seed.
    p_seed_after_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CLEAR && test_mode) |=> (key_q == (SEED & len_mask($past(len_sel)))));

    // R5: bits above the active length stay zero while running.
    p_upper_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RUN) |-> ((key_q & ~len_mask(len_q)) == '0));

    // R6: the generator never locks at zero.
    p_never_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RUN) |-> (key_q != '0));

    // R7: a scan shift moves bit 1 into bit 0.
    p_scan_rotate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RUN && test_mode && scan_en && len_sel == len_q)
        |=> (key_q[0] == $past(key_q[1])));

    // R8: a selector change reseeds ahead of any shift.
    p_reseed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RUN && test_mode && len_sel != len_q)
        |=> (key_q == (SEED & len_mask($past(len_sel)))));

    // R9: scan output falls silent after leaving test mode.
    p_scan_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |=> !scan_out);

    // R10: the key word is hidden for the whole test session.
    p_key_hidden_r10: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |=> (key_out == '0));

endmodule

// File: tb/secure_key_bist_tb.sv
`timescale 1ns/1ps
module secure_key_bist_tb;

    localparam logic [31:0] KEY  = 32'hC3A5_96E1;
    localparam logic [31:0] SEED = 32'h0000_0001;

    logic        clk = 1'b0;
    logic        rst_n, test_mode, scan_en;
    logic [1:0]  len_sel;
    logic [31:0] key_out;
    logic        scan_out;
    int          n_checks = 0;
    int          n_fail   = 0;

    always #10 clk = ~clk;

    secure_key_bist u_dut (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .len_sel(len_sel),
        .scan_en(scan_en), .key_out(key_out), .scan_out(scan_out)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int len_bits(input logic [1:0] s);
        return 4 << s;
    endfunction

    function automatic logic [31:0] mask_of(input logic [1:0] s);
        return (s == 2'd3) ? 32'hFFFF_FFFF : ((32'h1 << len_bits(s)) - 1);
    endfunction

    // Independent model of one generator step.
    function automatic logic [31:0] model_step(input logic [31:0] s, input logic [1:0] l);
        logic f;
        case (l)
            2'd0:    f = s[3] ^ s[2];
            2'd1:    f = s[7] ^ s[5] ^ s[4] ^ s[3];
            2'd2:    f = s[15] ^ s[13] ^ s[12] ^ s[10];
            default: f = s[31] ^ s[21] ^ s[1] ^ s[0];
        endcase
        return ((s << 1) | {31'd0, f}) & mask_of(l);
    endfunction

    // Enter test mode from safe mode; returns at the negedge after seeding.
    task automatic enter_test(input logic [1:0] l);
        @(negedge clk);
        test_mode = 1'b1; len_sel = l; scan_en = 1'b0;
        @(negedge clk);
        scan_en = 1'b1; #1;
        check(key_out == '0, "R10 key hidden in clear", key_out, 32'h0);
        check(scan_out == 1'b0, "R3 clear cycle scan quiet", {31'd0, scan_out}, 32'h0);
        @(negedge clk);
        scan_en = 1'b0;
    endtask

    // Scan out L bits LSB first; L shifts leave the state unchanged.
    task automatic read_state(input int l, output logic [31:0] v);
        v = '0;
        scan_en = 1'b1;
        for (int k = 0; k < l; k++) begin
            #1 v[k] = scan_out;
            @(negedge clk);
        end
        scan_en = 1'b0;
    endtask

    task automatic steps(input int n);
        scan_en = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic go_safe();
        @(negedge clk);
        test_mode = 1'b0; scan_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 180000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] got, got2, model;
        rst_n = 1'b0; test_mode = 1'b0; len_sel = 2'd0; scan_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check(key_out == KEY, "R1 reset key", key_out, KEY);
        check(scan_out == 1'b0, "R1 reset scan", {31'd0, scan_out}, 32'h0);

        // R2: safe mode ignores scan and length inputs.
        scan_en = 1'b1; len_sel = 2'd2;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk); #1;
            check(key_out == KEY, "R2 safe key", key_out, KEY);
            check(scan_out == 1'b0, "R2 safe scan", {31'd0, scan_out}, 32'h0);
        end
        scan_en = 1'b0;

        // Sweep every length.
        for (int l = 0; l < 4; l++) begin
            logic [1:0] ls;
            int         nb;
            ls = l[1:0];
            nb = len_bits(ls);
            enter_test(ls);
            read_state(nb, got);
            check(got == (SEED & mask_of(ls)), "R4 seed", got, SEED & mask_of(ls));
            read_state(nb, got2);
            check(got2 == got, "R7 scan restores state", got2, got);
            check(key_out == '0, "R10 key hidden in run", key_out, 32'h0);
            model = SEED & mask_of(ls);
            if (l < 2) begin
                int per;
                per = (1 << nb) - 1;
                for (int n = 1; n <= per; n++) begin
                    steps(1);
                    model = model_step(model, ls);
                    read_state(nb, got);
                    check(got == model, "R5 step value", got, model);
                    if (n < per)
                        check(got != SEED && got != 0, "R6 no early repeat", got, SEED);
                    else
                        check(got == SEED, "R6 period end", got, SEED);
                end
            end else if (l == 2) begin
                steps(100);
                for (int n = 0; n < 100; n++) model = model_step(model, ls);
                read_state(nb, got);
                check(got == model, "R5 step value 16", got, model);
                steps(65435);
                read_state(nb, got);
                check(got == SEED, "R6 period 16", got, SEED);
            end else begin
                steps(777);
                for (int n = 0; n < 777; n++) model = model_step(model, ls);
                read_state(nb, got);
                check(got == model, "R5 step value 32", got, model);
            end
            go_safe();
            #1 check(key_out == KEY, "R9 key reload", key_out, KEY);
        end

        // R8: length change and scan shift in the same cycle.
        enter_test(2'd3);
        steps(5);
        @(negedge clk);
        len_sel = 2'd1; scan_en = 1'b1;
        @(negedge clk);
        read_state(8, got);
        check(got == 32'h1, "R8 reseed beats shift", got, 32'h1);
        steps(3);
        model = 32'h1;
        for (int n = 0; n < 3; n++) model = model_step(model, 2'd1);
        read_state(8, got);
        check(got == model, "R8 runs at new length", got, model);

        // R9: leave test mode while scanning.
        scan_en = 1'b1;
        @(negedge clk);
        test_mode = 1'b0;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk); #1;
            check(key_out == KEY, "R9 key back while scan held", key_out, KEY);
            check(scan_out == 1'b0, "R9 scan quiet", {31'd0, scan_out}, 32'h0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule